// File: doc/BRIEF.md
# Page Access-Rights and Fault Checker

This block decides, for one memory access whose translation entry has already been looked up, which of read, write and execute the access may use and which fault, if any, it raises. Inputs are the entry's rights type, its two privilege bounds, its access identifier and its three page condition bits. Alongside them come the current privilege level, the kind of access, a protection-check enable, four protection-identifier registers, a break-bypass enable and the low address bits with the access size.

The result is an effective permission set, a write-once flag, a fault valid flag and an enumerated fault code. The same request also carries a branch target offset, and the block applies gateway-page privilege promotion to it. All results are registered and appear one clock after a request is presented with `in_valid_i`. They hold their value while no request is presented.

Top module: `pgchk_top`

## Requirements
- R1: Every result is registered. A request taken with `in_valid_i` high at an edge appears at that edge, with `res_valid_o` high for one cycle. Without `in_valid_i` the result outputs keep their values and `res_valid_o` is low. After reset all outputs are zero.
- R2: When `tlb_hit_i` is low, the fault code is 1 (instruction miss) for an execute request (kind 2) and 2 (data miss) for any other kind. The permission set is zero in both cases. A miss takes priority over every other fault.
- R3: Level 0 is the most privileged. Read is possible when priv ≤ read bound. Write is possible when priv ≤ write bound. Execute is possible when write bound ≤ priv ≤ read bound. Permission bits are bit0 read, bit1 write and bit2 execute.
- R4: Rights type 0 keeps read only. Type 1 keeps read and write. Type 2 keeps read and execute. Type 3 keeps all three. Types 4 to 7 keep execute only.
- R5: Access kinds are 0 read, 1 write, 2 execute and 3 probe. When the requested bit is missing from the rights permission set, the code is 3 (instruction protection) for execute and 4 (data rights) otherwise.
- R6: A protection check is made only when the entry identifier is nonzero and `pchk_en_i` is high. Each 17-bit register carries the identifier in bits 16:1 and a write-disable flag in bit 0. Registers are searched from index 0 upward. The first one whose identifier equals the entry's grants read and execute if its write-disable flag is set, and all three if it is clear. No match grants nothing.
- R7: If the grant lacks the requested bit, the code is 3 for execute and 5 (data protection identifier) otherwise. If the grant includes it, the permission set is ANDed with the grant.
- R8: A set reference-trap bit limits the permission set to execute. A non-execute access then gets code 6.
- R9: A clear dirty bit removes write permission. A write access then gets code 7.
- R10: A set break bit removes write permission. A write access then gets code 8, unless the bypass enable is set. In that case there is no fault and `write_once_o` is set. The conditions are applied in the order reference, dirty, break, and a later code replaces an earlier one.
- R11: An access of 2^size bytes whose low address bits under that size are nonzero gets code 9. This code replaces codes 6 to 8 and no fault, but not codes 1 to 5.
- R12: A probe (kind 3) that hits raises no fault and returns the rights permission set unchanged.
- R13: When rights type bit 2 is set and type bits 1:0 are numerically lower than offset bits 1:0, the branch offset output has those two bits replaced. Otherwise it equals the input offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request present; clock enable of the result registers |
| tlb_hit_i | input | 1 | A translation entry was found |
| ar_type_i | input | 3 | Rights type of the entry |
| pl_rd_i | input | 2 | Read privilege bound |
| pl_wr_i | input | 2 | Write privilege bound |
| access_id_i | input | ID_W | Entry protection identifier (0 = public) |
| ref_trap_i | input | 1 | Reference-trap bit of the entry |
| dirty_i | input | 1 | Dirty bit of the entry |
| brk_i | input | 1 | Break bit of the entry |
| cur_priv_i | input | 2 | Current privilege level |
| kind_i | input | 2 | 0 read, 1 write, 2 execute, 3 probe |
| pchk_en_i | input | 1 | Protection-identifier checking enable |
| pid_regs_i | input | NUM_PID*(ID_W+1) | Protection-identifier registers, register i at bits i*(ID_W+1) upward |
| wonce_en_i | input | 1 | Break-fault bypass enable |
| addr_lo_i | input | ALIGN_W | Low address bits |
| size_log2_i | input | SZ_W | Log2 of the access size in bytes |
| br_ofs_i | input | OFS_W | Branch target offset, privilege in bits 1:0 |
| res_valid_o | output | 1 | Result registered this cycle |
| perm_o | output | 3 | Effective permissions {execute, write, read} |
| write_once_o | output | 1 | Write allowed once under break bypass |
| fault_valid_o | output | 1 | A fault code is present |
| fault_code_o | output | 4 | Fault code |
| br_ofs_o | output | OFS_W | Offset after gateway promotion |

## Verification
Every result follows its request by exactly one clock edge. The bench therefore changes inputs on the falling edge and, on the next falling edge, compares all outputs with the prediction made for the inputs it had just applied. Cycles without a request predict held values and a low valid flag, which covers the hold behaviour at the same one-cycle offset. Directed cases cover each priority and boundary, and a pseudo-random run is compared against the same behavioural prediction every cycle.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_IPROT   = 4'd3,
    FLT_DRIGHTS = 4'd4,
    FLT_DPID    = 4'd5,
    FLT_PAGEREF = 4'd6,
    FLT_DIRTY   = 4'd7,
    FLT_BREAK   = 4'd8,
    FLT_UNALIGN = 4'd9
  } fault_e;

  typedef enum logic [1:0] {
    KIND_RD    = 2'd0,
    KIND_WR    = 2'd1,
    KIND_EX    = 2'd2,
    KIND_PROBE = 2'd3
  } kind_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_R = 3'b001;
  localparam logic [PERM_W-1:0] PERM_W_BIT = 3'b010;
  localparam logic [PERM_W-1:0] PERM_X = 3'b100;
  localparam logic [PERM_W-1:0] PERM_RX = 3'b101;
  localparam logic [PERM_W-1:0] PERM_RWX = 3'b111;
endpackage

// File: rtl/pgchk_rights.sv
module pgchk_rights
  import pgchk_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] pl_rd_i,
  input  logic [PRIV_W-1:0] pl_wr_i,
  input  logic [2:0]        ar_type_i,
  output logic [PERM_W-1:0] perm_o
);
  logic can_r, can_w, can_x;

  always_comb begin
    can_r = (priv_i <= pl_rd_i);
    can_w = (priv_i <= pl_wr_i);
    can_x = (pl_wr_i <= priv_i) && (priv_i <= pl_rd_i);
    unique case (ar_type_i)
      3'd0:    perm_o = {1'b0,  1'b0,  can_r};
      3'd1:    perm_o = {1'b0,  can_w, can_r};
      3'd2:    perm_o = {can_x, 1'b0,  can_r};
      3'd3:    perm_o = {can_x, can_w, can_r};
      default: perm_o = {can_x, 1'b0,  1'b0};
    endcase
  end
endmodule

// File: rtl/pgchk_pid.sv
module pgchk_pid
  import pgchk_pkg::*;
#(
  parameter int NUM_PID = 4,
  parameter int ID_W    = 16
) (
  input  logic [NUM_PID*(ID_W+1)-1:0] pid_regs_i,
  input  logic [ID_W-1:0]             access_id_i,
  output logic [PERM_W-1:0]           grant_o
);
  localparam int REG_W = ID_W + 1;

  logic [NUM_PID-1:0] match_v;
  logic [NUM_PID-1:0] wdis_v;

  for (genvar g = 0; g < NUM_PID; g++) begin : g_cmp
    assign match_v[g] = (pid_regs_i[g*REG_W+1 +: ID_W] == access_id_i);
    assign wdis_v[g]  = pid_regs_i[g*REG_W];
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_PID; i++) begin
      if (!found && match_v[i]) begin
        found   = 1'b1;
        grant_o = wdis_v[i] ? PERM_RX : PERM_RWX;
      end
    end
  end
endmodule

// File: rtl/pgchk_gate.sv
module pgchk_gate #(
  parameter int OFS_W  = 32,
  parameter int PRIV_W = 2
) (
  input  logic [2:0]       ar_type_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [PRIV_W-1:0] new_lvl;
  logic [PRIV_W-1:0] old_lvl;

  always_comb begin
    new_lvl = PRIV_W'(ar_type_i[1:0]);
    old_lvl = ofs_i[PRIV_W-1:0];
    ofs_o   = ofs_i;
    if (ar_type_i[2] && (new_lvl < old_lvl)) begin
      ofs_o[PRIV_W-1:0] = new_lvl;
    end
  end
endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
  import pgchk_pkg::*;
#(
  parameter int NUM_PID = 4,
  parameter int ID_W    = 16,
  parameter int ALIGN_W = 3,
  parameter int OFS_W   = 32,
  parameter int PRIV_W  = 2,
  localparam int SZ_W   = $clog2(ALIGN_W + 1),
  localparam int PIDS_W = NUM_PID * (ID_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  input  logic               tlb_hit_i,
  input  logic [2:0]         ar_type_i,
  input  logic [PRIV_W-1:0]  pl_rd_i,
  input  logic [PRIV_W-1:0]  pl_wr_i,
  input  logic [ID_W-1:0]    access_id_i,
  input  logic               ref_trap_i,
  input  logic               dirty_i,
  input  logic               brk_i,
  input  logic [PRIV_W-1:0]  cur_priv_i,
  input  logic [1:0]         kind_i,
  input  logic               pchk_en_i,
  input  logic [PIDS_W-1:0]  pid_regs_i,
  input  logic               wonce_en_i,
  input  logic [ALIGN_W-1:0] addr_lo_i,
  input  logic [SZ_W-1:0]    size_log2_i,
  input  logic [OFS_W-1:0]   br_ofs_i,
  output logic               res_valid_o,
  output logic [2:0]         perm_o,
  output logic               write_once_o,
  output logic               fault_valid_o,
  output logic [3:0]         fault_code_o,
  output logic [OFS_W-1:0]   br_ofs_o
);
  logic [PERM_W-1:0]  rights_perm;
  logic [PERM_W-1:0]  pid_grant;
  logic [OFS_W-1:0]   gate_ofs;
  logic [PERM_W-1:0]  req_bit;
  logic [ALIGN_W-1:0] align_mask;
  logic               is_exec, is_write, misaligned;

  logic [PERM_W-1:0]  perm_d;
  logic               wonce_d;
  fault_e             code_d;

  logic               valid_q;
  logic [PERM_W-1:0]  perm_q;
  logic               wonce_q;
  fault_e             code_q;
  logic [OFS_W-1:0]   ofs_q;

  pgchk_rights #(.PRIV_W(PRIV_W)) u_rights (
    .priv_i    (cur_priv_i),
    .pl_rd_i   (pl_rd_i),
    .pl_wr_i   (pl_wr_i),
    .ar_type_i (ar_type_i),
    .perm_o    (rights_perm)
  );

  pgchk_pid #(.NUM_PID(NUM_PID), .ID_W(ID_W)) u_pid (
    .pid_regs_i  (pid_regs_i),
    .access_id_i (access_id_i),
    .grant_o     (pid_grant)
  );

  pgchk_gate #(.OFS_W(OFS_W), .PRIV_W(PRIV_W)) u_gate (
    .ar_type_i (ar_type_i),
    .ofs_i     (br_ofs_i),
    .ofs_o     (gate_ofs)
  );

  // Request decode
  always_comb begin
    is_exec    = (kind_i == KIND_EX);
    is_write   = (kind_i == KIND_WR);
    unique case (kind_i)
      KIND_RD: req_bit = PERM_R;
      KIND_WR: req_bit = PERM_W_BIT;
      KIND_EX: req_bit = PERM_X;
      default: req_bit = '0;
    endcase
    align_mask = ALIGN_W'(~({ALIGN_W{1'b1}} << size_log2_i));
    misaligned = |(addr_lo_i & align_mask);
  end

  // Fault resolution in priority order
  always_comb begin
    perm_d  = rights_perm;
    wonce_d = 1'b0;
    code_d  = FLT_NONE;
    if (!tlb_hit_i) begin
      perm_d = '0;
      code_d = is_exec ? FLT_IMISS : FLT_DMISS;
    end else if (kind_i != KIND_PROBE) begin
      if (!(|(rights_perm & req_bit))) begin
        code_d = is_exec ? FLT_IPROT : FLT_DRIGHTS;
      end else if ((access_id_i != '0) && pchk_en_i &&
                   !(|(pid_grant & req_bit))) begin
        code_d = is_exec ? FLT_IPROT : FLT_DPID;
      end else begin
        if ((access_id_i != '0) && pchk_en_i) begin
          perm_d = perm_d & pid_grant;
        end
        if (ref_trap_i) begin
          perm_d = perm_d & PERM_X;
          if (!is_exec) code_d = FLT_PAGEREF;
        end
        if (!dirty_i) begin
          perm_d = perm_d & PERM_RX;
          if (is_write) code_d = FLT_DIRTY;
        end
        if (brk_i) begin
          perm_d = perm_d & PERM_RX;
          if (is_write) begin
            if (wonce_en_i) wonce_d = 1'b1;
            else            code_d  = FLT_BREAK;
          end
        end
        if (misaligned) code_d = FLT_UNALIGN;
      end
    end
  end

  // Result registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      perm_q  <= '0;
      wonce_q <= 1'b0;
      code_q  <= FLT_NONE;
      ofs_q   <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        perm_q  <= perm_d;
        wonce_q <= wonce_d;
        code_q  <= code_d;
        ofs_q   <= gate_ofs;
      end
    end
  end

  assign res_valid_o   = valid_q;
  assign perm_o        = perm_q;
  assign write_once_o  = wonce_q;
  assign fault_code_o  = code_q;
  assign fault_valid_o = (code_q != FLT_NONE);
  assign br_ofs_o      = ofs_q;
endmodule

// File: rtl/pgchk_chk.sv
module pgchk_chk #(
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic             tlb_hit_i,
  input logic [1:0]       kind_i,
  input logic [OFS_W-1:0] br_ofs_i,
  input logic             res_valid_o,
  input logic [2:0]       perm_o,
  input logic             write_once_o,
  input logic             fault_valid_o,
  input logic [3:0]       fault_code_o,
  input logic [OFS_W-1:0] br_ofs_o
);
  assert_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> res_valid_o);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!res_valid_o && $stable(perm_o) && $stable(fault_code_o)
                     && $stable(write_once_o) && $stable(br_ofs_o)));

  assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !tlb_hit_i) |=> (fault_valid_o && perm_o == 3'b000 &&
                                    (fault_code_o == 4'd1 || fault_code_o == 4'd2)));

  assert_wonce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_once_o |-> !perm_o[1]);

  assert_probe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && tlb_hit_i && kind_i == 2'd3) |=> !fault_valid_o);

  assert_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (br_ofs_o[OFS_W-1:2] == $past(br_ofs_i[OFS_W-1:2]) &&
                    br_ofs_o[1:0] <= $past(br_ofs_i[1:0])));
endmodule

bind pgchk_top pgchk_chk #(.OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid_i    (in_valid_i),
  .tlb_hit_i     (tlb_hit_i),
  .kind_i        (kind_i),
  .br_ofs_i      (br_ofs_i),
  .res_valid_o   (res_valid_o),
  .perm_o        (perm_o),
  .write_once_o  (write_once_o),
  .fault_valid_o (fault_valid_o),
  .fault_code_o  (fault_code_o),
  .br_ofs_o      (br_ofs_o)
);

// File: tb/pgchk_tb.sv
module pgchk_top_tb_top;
  localparam int NUM_PID = 4;
  localparam int ID_W    = 16;
  localparam int ALIGN_W = 3;
  localparam int OFS_W   = 32;
  localparam int REG_W   = ID_W + 1;

  logic clk, rst_n;
  logic in_valid, hit, tb, dirty, brk, pchk, wonce;
  logic [2:0] ar_type;
  logic [1:0] pl_rd, pl_wr, priv, kind, size_l;
  logic [ID_W-1:0] acc_id;
  logic [NUM_PID*REG_W-1:0] pids;
  logic [ALIGN_W-1:0] addr_lo;
  logic [OFS_W-1:0] ofs;
  logic res_valid, wo_o, fv_o;
  logic [2:0] perm_out;
  logic [3:0] code_out;
  logic [OFS_W-1:0] ofs_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values
  logic       e_valid;
  logic [2:0] e_perm;
  logic       e_wo;
  logic [3:0] e_code;
  logic [OFS_W-1:0] e_ofs;
  string      e_tag;

  pgchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .tlb_hit_i(hit),
    .ar_type_i(ar_type), .pl_rd_i(pl_rd), .pl_wr_i(pl_wr),
    .access_id_i(acc_id), .ref_trap_i(tb), .dirty_i(dirty), .brk_i(brk),
    .cur_priv_i(priv), .kind_i(kind), .pchk_en_i(pchk), .pid_regs_i(pids),
    .wonce_en_i(wonce), .addr_lo_i(addr_lo), .size_log2_i(size_l),
    .br_ofs_i(ofs), .res_valid_o(res_valid), .perm_o(perm_out),
    .write_once_o(wo_o), .fault_valid_o(fv_o), .fault_code_o(code_out),
    .br_ofs_o(ofs_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic set_pid(input int idx, input logic [ID_W-1:0] id, input logic wd);
    pids[idx*REG_W +: REG_W] = {id, wd};
  endtask

  task automatic base();
    in_valid = 1; hit = 1; ar_type = 3; pl_rd = 3; pl_wr = 0; priv = 0;
    acc_id = 0; tb = 0; dirty = 1; brk = 0; pchk = 0; wonce = 0;
    addr_lo = 0; size_l = 0; kind = 0; ofs = 32'h0000_0100;
  endtask

  // Behavioural prediction for the inputs just applied
  task automatic predict();
    int p, req, g;
    bit r, w, x, pidf;
    if (!in_valid) begin
      e_valid = 0;
      return;
    end
    e_valid = 1;
    r = (priv <= pl_rd);
    w = (priv <= pl_wr);
    x = (pl_wr <= priv) && (priv <= pl_rd);
    case (ar_type)
      0: p = r;
      1: p = r + 2*w;
      2: p = r + 4*x;
      3: p = r + 2*w + 4*x;
      default: p = 4*x;
    endcase
    e_wo = 0;
    e_code = 0;
    if (!hit) begin
      p = 0;
      e_code = (kind == 2) ? 1 : 2;
    end else if (kind != 3) begin
      req = (kind == 0) ? 1 : (kind == 1) ? 2 : 4;
      if ((p & req) == 0) begin
        e_code = (kind == 2) ? 3 : 4;
      end else begin
        pidf = 0;
        if (acc_id != 0 && pchk) begin
          g = 0;
          for (int i = 0; i < NUM_PID; i++) begin
            if (g == 0 && pids[i*REG_W+1 +: ID_W] == acc_id)
              g = pids[i*REG_W] ? 5 : 7;
          end
          if ((g & req) == 0) begin
            e_code = (kind == 2) ? 3 : 5;
            pidf = 1;
          end else p = p & g;
        end
        if (!pidf) begin
          if (tb) begin p = p & 4; if (kind != 2) e_code = 6; end
          if (!dirty) begin p = p & 5; if (kind == 1) e_code = 7; end
          if (brk) begin
            p = p & 5;
            if (kind == 1) begin
              if (wonce) e_wo = 1; else e_code = 8;
            end
          end
          if ((int'(addr_lo) & ((1 << size_l) - 1)) != 0) e_code = 9;
        end
      end
    end
    e_perm = p[2:0];
    e_ofs = ofs;
    if (ar_type[2] && ar_type[1:0] < ofs[1:0]) e_ofs[1:0] = ar_type[1:0];
  endtask

  task automatic compare();
    bit bad;
    checks++;
    bad = (res_valid !== e_valid) || (perm_out !== e_perm) || (wo_o !== e_wo) ||
          (code_out !== e_code) || (fv_o !== (e_code != 0)) || (ofs_out !== e_ofs);
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b perm=%03b wo=%0b code=%0d ofs=%h, expected v=%0b perm=%03b wo=%0b code=%0d ofs=%h",
               e_tag, res_valid, perm_out, wo_o, code_out, ofs_out,
               e_valid, e_perm, e_wo, e_code, e_ofs);
    end
  endtask

  // Apply current inputs, then check one cycle later
  task automatic step(input string tag);
    predict();
    e_tag = tag;
    @(negedge clk);
    compare();
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      1, 2: return "R2";
      3, 4: return "R5";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      9: return "R11";
      default: return "R3";
    endcase
  endfunction

  initial begin
    rst_n = 0;
    pids = '0;
    base();
    in_valid = 0;
    e_valid = 0; e_perm = 0; e_wo = 0; e_code = 0; e_ofs = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    compare();  // R1 reset state
    rst_n = 1;
    @(negedge clk);

    // R1 basic registered result then hold
    base(); step("R1");
    base(); in_valid = 0; step("R1");
    // R2 misses
    base(); hit = 0; kind = 2; step("R2");
    base(); hit = 0; kind = 0; step("R2");
    base(); hit = 0; kind = 3; addr_lo = 1; size_l = 1; step("R2");
    // R3 privilege window
    base(); priv = 1; pl_rd = 2; pl_wr = 0; kind = 0; step("R3");
    base(); priv = 3; pl_rd = 2; kind = 0; step("R3");
    base(); priv = 1; pl_wr = 0; kind = 1; step("R3");
    base(); priv = 0; pl_wr = 1; kind = 2; step("R3");
    base(); priv = 2; pl_rd = 2; pl_wr = 2; kind = 2; step("R3");
    // R4 rights types
    base(); ar_type = 0; kind = 1; step("R4");
    base(); ar_type = 4; kind = 0; step("R4");
    base(); ar_type = 5; kind = 2; step("R4");
    base(); ar_type = 1; kind = 2; step("R5");
    // R6 / R7 protection identifiers
    set_pid(0, 16'h0042, 0); set_pid(1, 16'h1234, 0);
    set_pid(2, 16'h5555, 1); set_pid(3, 16'h5555, 0);
    base(); acc_id = 16'h5555; pchk = 1; kind = 1; step("R7");
    base(); acc_id = 16'h5555; pchk = 1; kind = 0; step("R6");
    base(); acc_id = 16'h5555; pchk = 0; kind = 1; step("R6");
    base(); acc_id = 16'h7777; pchk = 1; kind = 2; step("R7");
    base(); acc_id = 16'h1234; pchk = 1; kind = 1; step("R6");
    set_pid(1, 16'h5555, 0);
    base(); acc_id = 16'h5555; pchk = 1; kind = 1; step("R6");
    // R8 reference trap
    base(); tb = 1; kind = 0; step("R8");
    base(); tb = 1; kind = 2; step("R8");
    // R9 dirty
    base(); dirty = 0; kind = 1; step("R9");
    base(); dirty = 0; kind = 0; step("R9");
    // R10 break, order, bypass
    base(); brk = 1; dirty = 0; kind = 1; step("R10");
    base(); tb = 1; dirty = 0; kind = 1; step("R10");
    base(); brk = 1; wonce = 1; kind = 1; step("R10");
    // R11 alignment
    base(); dirty = 0; kind = 1; size_l = 2; addr_lo = 2; step("R11");
    base(); ar_type = 0; kind = 1; size_l = 2; addr_lo = 2; step("R11");
    base(); kind = 0; size_l = 2; addr_lo = 4; step("R11");
    base(); brk = 1; wonce = 1; kind = 1; size_l = 3; addr_lo = 1; step("R11");
    // R12 probe
    base(); ar_type = 0; priv = 3; pl_rd = 2; kind = 3; step("R12");
    base(); kind = 3; tb = 1; dirty = 0; size_l = 3; addr_lo = 7; step("R12");
    // R13 gateway
    base(); ar_type = 5; ofs = 32'hABCD_0003; step("R13");
    base(); ar_type = 6; ofs = 32'hABCD_0001; step("R13");
    base(); ar_type = 2; ofs = 32'hABCD_0003; step("R13");

    // pseudo-random sweep
    void'($urandom(7));
    for (int n = 0; n < 400; n++) begin
      in_valid = ($urandom % 8) != 0;
      hit = ($urandom % 10) != 0;
      ar_type = 3'($urandom); pl_rd = 2'($urandom); pl_wr = 2'($urandom);
      priv = 2'($urandom); kind = 2'($urandom);
      acc_id = ($urandom % 2) ? 16'h0 : 16'($urandom % 4 + 16'h5554);
      tb = ($urandom % 4) == 0; dirty = ($urandom % 4) != 0; brk = ($urandom % 4) == 0;
      pchk = 1'($urandom); wonce = 1'($urandom);
      addr_lo = 3'($urandom); size_l = 2'($urandom); ofs = $urandom;
      if (in_valid) begin
        predict();
        step(tag_of(e_code));
      end else step("R1");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule